// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block is a bank of general-purpose lines (32 by default) that turns activity on its input pins into interrupt and wakeup requests. Each line passes through a synchronizer. Four per-line masks then pick which conditions count as an event: the line held low, the line held high, a low-to-high transition, or a high-to-low transition. Any combination of the four is allowed. Each event sets a sticky status bit. Software clears a status bit by writing a one to it.

The interrupt output is asserted while any status bit has its enable bit set. The wakeup output works the same way, using a separate wakeup-enable mask. The same bank also holds the line direction register and the output data register. Both the output data and the interrupt enable can be changed bit-selectively through set and clear aliases, so software never needs a read-modify-write. A readback register returns, for each line, the synchronized pin when the line is an input and the driven value when it is an output. A control bit stops the bank from recording any new event.

Software reaches every register through a single-cycle register port. A write takes effect at the clock edge where `reg_we` is high. A read is combinational on `reg_addr`.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset the direction register (address 1) reads all ones, so every line is an input. Output data, interrupt enable, wakeup enable, all four detect masks, status and control read zero, and `irq` and `wake` are low.
- R2: A change on `pad_in` reaches the readback register (address 14) after exactly two rising clock edges. It is not visible after the first edge.
- R3: A line whose bit is set in the low-level mask (address 9) records an event on every cycle its synchronized input is 0. A line whose bit is set in the high-level mask (address 10) records an event on every cycle its synchronized input is 1.
- R4: A line whose bit is set in the rising mask (address 11) records one event per 0-to-1 transition. A line whose bit is set in the falling mask (address 12) records one event per 1-to-0 transition. An edge whose mask bit is clear records nothing. A line may have both edge masks set at once.
- R5: Status (address 13, bit i belongs to line i) is sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. The clear takes priority over an event in the same cycle, so a level condition that is still active sets the bit again on the next cycle.
- R6: Output data (address 2) may be written directly. Writing a mask to address 3 sets exactly the mask's one-bits, and writing a mask to address 4 clears exactly those bits. `pad_out` always reflects this register.
- R7: Interrupt enable (address 5) may be written directly. Address 6 sets the one-bits of the written mask and address 7 clears them, leaving all other bits unchanged.
- R8: `irq` is high exactly when some status bit has its interrupt-enable bit set.
- R9: `wake` is high exactly when some status bit has its wakeup-enable bit (address 8) set.
- R10: Readback (address 14) bit i returns the synchronized input when direction bit i is 1 (input), and the output data bit when direction bit i is 0 (output). `pad_in_mode` mirrors the direction register.
- R11: While control bit 0 (address 0) is 1, no status bit is set. Bits already set are kept. An edge that happens while the bank is gated is not recorded after the gate is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | NLINES | Register write data |
| reg_rdata | output | NLINES | Register read data (combinational on address) |
| pad_in | input | NLINES | Asynchronous pin inputs |
| pad_out | output | NLINES | Output data driven toward the pins |
| pad_in_mode | output | NLINES | Per-line direction, 1 means input |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Combined wakeup request |

## Verification
The bench reads status on the same cycle as a write-one-to-clear while a level condition is still active. It expects the bit to read zero there and to be set again one cycle later. A design that lets the event win would never show the zero, and one that drops the re-set would lose a pending level interrupt. The bench also checks readback one edge too early, to catch a synchronizer with the wrong depth. It releases the gate after an edge that occurred while gated, so a design whose previous-sample register froze during the gate would record a phantom event. Finally it writes partial masks through the set and clear aliases, so any alias that disturbs bits outside the mask shows up as a wrong neighbour bit.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] RA_CTRL     = 4'd0;
   localparam logic [ADDR_W-1:0] RA_DIR      = 4'd1;
   localparam logic [ADDR_W-1:0] RA_DOUT     = 4'd2;
   localparam logic [ADDR_W-1:0] RA_DOUT_SET = 4'd3;
   localparam logic [ADDR_W-1:0] RA_DOUT_CLR = 4'd4;
   localparam logic [ADDR_W-1:0] RA_IEN      = 4'd5;
   localparam logic [ADDR_W-1:0] RA_IEN_SET  = 4'd6;
   localparam logic [ADDR_W-1:0] RA_IEN_CLR  = 4'd7;
   localparam logic [ADDR_W-1:0] RA_WAKE     = 4'd8;
   localparam logic [ADDR_W-1:0] RA_LOW      = 4'd9;
   localparam logic [ADDR_W-1:0] RA_HIGH     = 4'd10;
   localparam logic [ADDR_W-1:0] RA_RISE     = 4'd11;
   localparam logic [ADDR_W-1:0] RA_FALL     = 4'd12;
   localparam logic [ADDR_W-1:0] RA_STAT     = 4'd13;
   localparam logic [ADDR_W-1:0] RA_RDBK     = 4'd14;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic         gate,
   input  logic [W-1:0] lo_m,
   input  logic [W-1:0] hi_m,
   input  logic [W-1:0] ri_m,
   input  logic [W-1:0] fa_m,
   output logic [W-1:0] ev
);
   logic [W-1:0] prev;

   // previous sample keeps tracking while gated so no stale edge appears later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      logic lvl_hit, edg_hit;
      assign lvl_hit = (lo_m[i] && !smp[i]) || (hi_m[i] && smp[i]);
      assign edg_hit = (ri_m[i] && smp[i] && !prev[i]) ||
                       (fa_m[i] && !smp[i] && prev[i]);
      assign ev[i]   = !gate && (lvl_hit || edg_hit);
   end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
   import gpio_evt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      rdata,
   input  logic [W-1:0]      smp,
   input  logic [W-1:0]      ev,
   output logic              gate_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      dout_q,
   output logic [W-1:0]      ien_q,
   output logic [W-1:0]      wen_q,
   output logic [W-1:0]      lo_q,
   output logic [W-1:0]      hi_q,
   output logic [W-1:0]      ri_q,
   output logic [W-1:0]      fa_q,
   output logic [W-1:0]      stat_q
);
   logic [W-1:0] clr_mask;
   logic [W-1:0] rdbk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         dir_q  <= '1;
         dout_q <= '0;
         ien_q  <= '0;
         wen_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         ri_q   <= '0;
         fa_q   <= '0;
      end else if (we) begin
         case (addr)
            RA_CTRL:     gate_q <= wdata[0];
            RA_DIR:      dir_q  <= wdata;
            RA_DOUT:     dout_q <= wdata;
            RA_DOUT_SET: dout_q <= dout_q | wdata;
            RA_DOUT_CLR: dout_q <= dout_q & ~wdata;
            RA_IEN:      ien_q  <= wdata;
            RA_IEN_SET:  ien_q  <= ien_q | wdata;
            RA_IEN_CLR:  ien_q  <= ien_q & ~wdata;
            RA_WAKE:     wen_q  <= wdata;
            RA_LOW:      lo_q   <= wdata;
            RA_HIGH:     hi_q   <= wdata;
            RA_RISE:     ri_q   <= wdata;
            RA_FALL:     fa_q   <= wdata;
            default: ;
         endcase
      end
   end

   assign clr_mask = (we && addr == RA_STAT) ? wdata : '0;

   // clear wins over a same-cycle event; a live level re-sets next cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q | ev) & ~clr_mask;
   end

   assign rdbk = (dir_q & smp) | (~dir_q & dout_q);

   always_comb begin
      case (addr)
         RA_CTRL:                        rdata = {{(W-1){1'b0}}, gate_q};
         RA_DIR:                         rdata = dir_q;
         RA_DOUT, RA_DOUT_SET, RA_DOUT_CLR: rdata = dout_q;
         RA_IEN, RA_IEN_SET, RA_IEN_CLR:    rdata = ien_q;
         RA_WAKE:                        rdata = wen_q;
         RA_LOW:                         rdata = lo_q;
         RA_HIGH:                        rdata = hi_q;
         RA_RISE:                        rdata = ri_q;
         RA_FALL:                        rdata = fa_q;
         RA_STAT:                        rdata = stat_q;
         RA_RDBK:                        rdata = rdbk;
         default:                        rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
   import gpio_evt_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [NLINES-1:0] reg_wdata,
   output logic [NLINES-1:0] reg_rdata,
   input  logic [NLINES-1:0] pad_in,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_in_mode,
   output logic              irq,
   output logic              wake
);
   if (NLINES < 2 || NLINES > 32) begin : g_bad_width
      $error("gpio_evt_top: NLINES must lie in 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_evt_top: SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] smp, ev;
   logic              gate_w;
   logic [NLINES-1:0] dir_w, dout_w, ien_w, wen_w;
   logic [NLINES-1:0] lo_w, hi_w, ri_w, fa_w, stat_w;

   gpio_evt_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(smp)
   );

   gpio_evt_detect #(.W(NLINES)) u_det (
      .clk(clk), .rst_n(rst_n), .smp(smp), .gate(gate_w),
      .lo_m(lo_w), .hi_m(hi_w), .ri_m(ri_w), .fa_m(fa_w), .ev(ev)
   );

   gpio_evt_regs #(.W(NLINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .smp(smp), .ev(ev),
      .gate_q(gate_w), .dir_q(dir_w), .dout_q(dout_w), .ien_q(ien_w),
      .wen_q(wen_w), .lo_q(lo_w), .hi_q(hi_w), .ri_q(ri_w), .fa_q(fa_w),
      .stat_q(stat_w)
   );

   assign pad_out     = dout_w;
   assign pad_in_mode = dir_w;
   assign irq         = |(stat_w & ien_w);
   assign wake        = |(stat_w & wen_w);
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
   import gpio_evt_pkg::*;
#(
   parameter int W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [W-1:0]      reg_wdata,
   input logic [W-1:0]      pad_out,
   input logic              irq,
   input logic              wake,
   input logic [W-1:0]      status,
   input logic [W-1:0]      ien,
   input logic [W-1:0]      wen,
   input logic              gate
);
   p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_STAT) |=> ((status & $past(reg_wdata)) == '0));

   p_gate_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !(reg_we && reg_addr == RA_STAT)) |=> ((status & ~$past(status)) == '0));

   p_dout_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_DOUT_SET) |=>
         (((pad_out & $past(reg_wdata)) == $past(reg_wdata)) &&
          ((pad_out & ~$past(reg_wdata)) == ($past(pad_out) & ~$past(reg_wdata)))));

   p_dout_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_DOUT_CLR) |=>
         (((pad_out & $past(reg_wdata)) == '0) &&
          ((pad_out & ~$past(reg_wdata)) == ($past(pad_out) & ~$past(reg_wdata)))));

   p_ien_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_IEN_CLR) |=> ((ien & $past(reg_wdata)) == '0));

   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien != '0 && status != '0));

   p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (wen != '0 && status != '0));
endmodule

bind gpio_evt_top gpio_evt_chk #(.W(NLINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .pad_out(pad_out), .irq(irq), .wake(wake),
   .status(stat_w), .ien(ien_w), .wen(wen_w), .gate(gate_w)
);

// File: tb/gpio_evt_top_bench.sv
module gpio_evt_top_bench;
   import gpio_evt_pkg::*;

   localparam int N = 32;
   localparam int K_RD = 0, K_IRQ = 1, K_WAKE = 2, K_POUT = 3;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              reg_we;
   logic [ADDR_W-1:0] reg_addr;
   logic [N-1:0]      reg_wdata, reg_rdata, pad_in, pad_out, pad_in_mode;
   logic              irq, wake;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   always #5 clk = ~clk;

   gpio_evt_top u_gpio_evt_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_in_mode(pad_in_mode), .irq(irq), .wake(wake)
   );

   // monitor: compares queued expectations just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               K_RD:    act = reg_rdata;
               K_IRQ:   act = {31'd0, irq};
               K_WAKE:  act = {31'd0, wake};
               default: act = pad_out;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic wr_chk(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      push(K_RD, exp, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         reg_we = 1'b0;
      end
   endtask

   task automatic chk(input int kind, input logic [ADDR_W-1:0] a,
                      input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      push(kind, exp, tag);
   endtask

   task automatic pad(input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b0; pad_in = v;
   endtask

   task automatic clr_all();
      wr(RA_STAT, 32'hFFFF_FFFF);
      idle(1);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pad_in = '0;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(K_RD, RA_DIR,  32'hFFFF_FFFF, "R1 dir");
      chk(K_RD, RA_DOUT, 32'h0, "R1 dout");
      chk(K_RD, RA_IEN,  32'h0, "R1 ien");
      chk(K_RD, RA_STAT, 32'h0, "R1 status");
      chk(K_RD, RA_CTRL, 32'h0, "R1 ctrl");
      chk(K_IRQ, RA_STAT, 32'h0, "R1 irq");
      chk(K_WAKE, RA_STAT, 32'h0, "R1 wake");

      // R6 output data aliases
      wr(RA_DOUT, 32'h0000_00F0);
      wr(RA_DOUT_SET, 32'h0000_0F0F);
      chk(K_RD, RA_DOUT, 32'h0000_0FFF, "R6 set alias");
      wr(RA_DOUT_CLR, 32'h0000_00F3);
      chk(K_RD, RA_DOUT, 32'h0000_0F0C, "R6 clr alias");
      chk(K_POUT, RA_DOUT, 32'h0000_0F0C, "R6 pad_out");

      // R7 interrupt enable aliases
      wr(RA_IEN_SET, 32'h5);
      wr(RA_IEN_SET, 32'h30);
      chk(K_RD, RA_IEN, 32'h35, "R7 set alias");
      wr(RA_IEN_CLR, 32'h11);
      chk(K_RD, RA_IEN, 32'h24, "R7 clr alias");
      wr(RA_IEN, 32'h0);

      // R10 / R2 readback and synchronizer depth
      wr(RA_DIR, 32'hFFFF_FF00);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = RA_RDBK; pad_in = 32'h0000_FFFF;
      push(K_RD, 32'h0000_000C, "R2 one edge too early");
      chk(K_RD, RA_RDBK, 32'h0000_FF0C, "R10 readback mix");
      wr(RA_DIR, 32'hFFFF_FFFF);
      pad(32'h0);
      idle(3);
      chk(K_RD, RA_STAT, 32'h0, "R4 unmasked activity ignored");

      // R4 edges
      wr(RA_RISE, 32'h1);
      pad(32'h1);
      idle(3);
      chk(K_RD, RA_STAT, 32'h1, "R4 rising");
      wr_chk(RA_STAT, 32'hFFFF_FFFF, 32'h0, "R5 clear");
      idle(2);
      chk(K_RD, RA_STAT, 32'h0, "R4 single event per edge");
      pad(32'h0);
      idle(3);
      chk(K_RD, RA_STAT, 32'h0, "R4 falling not enabled");
      wr(RA_FALL, 32'h1);
      pad(32'h1);
      idle(3);
      chk(K_RD, RA_STAT, 32'h1, "R4 both masks rise");
      clr_all();
      pad(32'h0);
      idle(3);
      chk(K_RD, RA_STAT, 32'h1, "R4 both masks fall");
      clr_all();
      wr(RA_RISE, 32'h0);
      wr(RA_FALL, 32'h0);

      // R5 write-one-to-clear partial
      wr(RA_RISE, 32'h6);
      pad(32'h6);
      idle(3);
      chk(K_RD, RA_STAT, 32'h6, "R5 two bits set");
      wr(RA_STAT, 32'h0);
      chk(K_RD, RA_STAT, 32'h6, "R5 zero write no effect");
      wr(RA_STAT, 32'h2);
      chk(K_RD, RA_STAT, 32'h4, "R5 partial clear");
      clr_all();
      wr(RA_RISE, 32'h0);
      pad(32'h0);
      idle(3);

      // R3 levels
      wr(RA_HIGH, 32'h200);
      idle(3);
      chk(K_RD, RA_STAT, 32'h0, "R3 high mask, line low");
      pad(32'h200);
      idle(3);
      chk(K_RD, RA_STAT, 32'h200, "R3 high level");
      wr(RA_LOW, 32'h100);
      idle(2);
      chk(K_RD, RA_STAT, 32'h300, "R3 low level");
      wr_chk(RA_STAT, 32'h300, 32'h0, "R5 clear beats live level");
      chk(K_RD, RA_STAT, 32'h300, "R5 level re-sets next cycle");

      // R8 irq
      chk(K_IRQ, RA_STAT, 32'h0, "R8 no enable");
      wr(RA_IEN_SET, 32'h1);
      chk(K_IRQ, RA_STAT, 32'h0, "R8 enable without status");
      wr(RA_IEN_SET, 32'h100);
      chk(K_IRQ, RA_STAT, 32'h1, "R8 enabled status");

      // R9 wake
      chk(K_WAKE, RA_STAT, 32'h0, "R9 no wake enable");
      wr(RA_WAKE, 32'h400);
      chk(K_WAKE, RA_STAT, 32'h0, "R9 wake enable without status");
      wr(RA_WAKE, 32'h200);
      chk(K_WAKE, RA_STAT, 32'h1, "R9 wake asserted");

      pad(32'h100);
      idle(3);
      clr_all();
      chk(K_RD, RA_STAT, 32'h0, "R3 levels released");
      chk(K_IRQ, RA_STAT, 32'h0, "R8 irq drops");
      wr(RA_LOW, 32'h0);
      wr(RA_HIGH, 32'h0);
      wr(RA_IEN, 32'h0);
      wr(RA_WAKE, 32'h0);

      // R11 gating
      wr(RA_RISE, 32'h1);
      wr(RA_CTRL, 32'h1);
      chk(K_RD, RA_CTRL, 32'h1, "R11 ctrl readback");
      pad(32'h101);
      idle(3);
      chk(K_RD, RA_STAT, 32'h0, "R11 gated edge ignored");
      wr(RA_CTRL, 32'h0);
      idle(3);
      chk(K_RD, RA_STAT, 32'h0, "R11 gated edge not replayed");
      pad(32'h100);
      idle(3);
      pad(32'h101);
      idle(3);
      chk(K_RD, RA_STAT, 32'h1, "R11 ungated edge recorded");
      wr(RA_CTRL, 32'h1);
      idle(2);
      chk(K_RD, RA_STAT, 32'h1, "R11 status kept while gated");

      idle(2);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule